// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port with a word-addressed register interface. Software uses it to drive output pins, set which pins are driven, and read the pin levels after a synchronizer. Each pin can also flag an interrupt. The condition is chosen per pin and can be a high level, a low level, a rising edge, a falling edge, or any edge. Detected events latch into a sticky status register, which software clears by writing ones.

Each status bit is gated by a per-pin mask before it reaches an interrupt line. There are two interrupt lines. One collects the lower half of the pins and the other collects the upper half, so the two halves can be routed to separate interrupt controller inputs.

The bus is a single strobe. `bus_valid` with `bus_write` high performs a write. `bus_valid` with `bus_write` low requests a read, and its data returns on the following cycle with `bus_rvalid`. The port accepts a request on every cycle and never stalls, so there is no back-pressure. The read response is not held: it is valid for exactly one cycle.

Top module: `gpio_irq_port`

## Requirements
- R1: Register word indices are 0 output data, 1 direction, 2 pad level (read-only), 3 trigger config for the lower pins, 4 trigger config for the upper pins, 5 mask, 6 status, 7 any-edge select. A write to index 0 or 1 updates that register. Reads of index 0 return the last value written, whatever the pins carry. `pad_oe` equals the direction register (1 means output), and `pad_out` equals output data AND direction.
- R2: Index 2 returns `pad_in` after a two-flop synchronizer, so a pin change is readable on the third clock edge after it. Writes to index 2 change nothing.
- R3: Pin n below the half point uses bits [2n+1:2n] of the lower config register. Pin n at or above the half point uses bits [2(n-16)+1:2(n-16)] of the upper config register.
- R4: Trigger codes are 00 for low level, 01 for high level, 10 for rising edge and 11 for falling edge. A change of the synchronized pin sets its status bit on the clock edge after it becomes visible at index 2.
- R5: When a pin's bit in the any-edge register (index 7) is 1, both rising and falling edges set its status bit, and its 2-bit code is ignored.
- R6: Status bits are sticky. Writing 1 to a status bit clears it, writing 0 leaves it, and without a write a set bit never drops.
- R7: While a level condition holds, its status bit is set again on every cycle. When a clear and a set meet in the same cycle, the set wins.
- R8: A pin reaches an interrupt line only while its mask bit is 1. With a mask of zero, both lines are low.
- R9: `irq_lo` is the OR of masked status for pins 0 to 15, and `irq_hi` is the OR for pins 16 to 31.
- R10: Reset clears every register and both outputs. A read request yields `bus_rvalid` on exactly the next cycle, carrying the value the register held when the request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Pin drive value |
| pad_oe | output | 32 | Pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
Each trigger code is exercised on its own pin. Rising edge uses pin 3, falling edge pin 20, high level pin 5 and low level pin 30. Each pin is driven through both of its transitions, which shows that an edge code fires on one direction only and a level code keeps firing. The level pin is cleared while its level is still active, which separates a sticky-with-reassert status from a plain sticky one. The any-edge bit is applied on top of a rising code and on top of a low-level code, which shows that the override really ignores the field. Last, status is built up in both halves at once and then cleared half by half, which tells the two interrupt lines apart.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_DATA   = 3'd0;
  localparam logic [REG_AW-1:0] RA_DIR    = 3'd1;
  localparam logic [REG_AW-1:0] RA_PAD    = 3'd2;
  localparam logic [REG_AW-1:0] RA_CFG_LO = 3'd3;
  localparam logic [REG_AW-1:0] RA_CFG_HI = 3'd4;
  localparam logic [REG_AW-1:0] RA_MASK   = 3'd5;
  localparam logic [REG_AW-1:0] RA_STAT   = 3'd6;
  localparam logic [REG_AW-1:0] RA_ANYEDG = 3'd7;

  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'b00,
    TRIG_LEVEL_HIGH = 2'b01,
    TRIG_RISE       = 2'b10,
    TRIG_FALL       = 2'b11
  } trig_code_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic       level_now,
  input  logic       level_prev,
  input  logic [1:0] code,
  input  logic       any_edge,
  output logic       hit
);
  logic rose, fell;
  trig_code_e mode;

  assign rose = level_now & ~level_prev;
  assign fell = ~level_now & level_prev;
  assign mode = trig_code_e'(code);

  always_comb begin
    if (any_edge) begin
      hit = rose | fell;
    end else begin
      unique case (mode)
        TRIG_LEVEL_LOW:  hit = ~level_now;
        TRIG_LEVEL_HIGH: hit = level_now;
        TRIG_RISE:       hit = rose;
        TRIG_FALL:       hit = fell;
        default:         hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic              bus_rvalid,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q, anyedg_q;
  logic [PINS-1:0] pad_sync, pad_prev_q, hit;
  logic [PINS-1:0] eff_req;
  logic            wr_en, rd_en;

  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;

  gpio_irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad_prev_q <= '0;
    else        pad_prev_q <= pad_sync;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] code;
    if (i < HALF) begin : g_low
      assign code = cfg_lo_q[2*i +: 2];
    end else begin : g_high
      assign code = cfg_hi_q[2*(i-HALF) +: 2];
    end
    gpio_irq_detect u_det (
      .level_now  (pad_sync[i]),
      .level_prev (pad_prev_q[i]),
      .code       (code),
      .any_edge   (anyedg_q[i]),
      .hit        (hit[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      anyedg_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        RA_DATA:   data_q   <= bus_wdata;
        RA_DIR:    dir_q    <= bus_wdata;
        RA_CFG_LO: cfg_lo_q <= bus_wdata;
        RA_CFG_HI: cfg_hi_q <= bus_wdata;
        RA_MASK:   mask_q   <= bus_wdata;
        RA_ANYEDG: anyedg_q <= bus_wdata;
        default:   ;
      endcase
    end
  end

  // Sticky status: clear by writing ones, a new hit in the same cycle wins.
  logic [PINS-1:0] clr_vec;
  assign clr_vec = (wr_en && bus_addr == RA_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_vec) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) begin
        case (bus_addr)
          RA_DATA:   bus_rdata <= data_q;
          RA_DIR:    bus_rdata <= dir_q;
          RA_PAD:    bus_rdata <= pad_sync;
          RA_CFG_LO: bus_rdata <= cfg_lo_q;
          RA_CFG_HI: bus_rdata <= cfg_hi_q;
          RA_MASK:   bus_rdata <= mask_q;
          RA_STAT:   bus_rdata <= stat_q;
          RA_ANYEDG: bus_rdata <= anyedg_q;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  assign eff_req = stat_q & mask_q;
  assign irq_lo  = |eff_req[HALF-1:0];
  assign irq_hi  = |eff_req[PINS-1:HALF];
  assign pad_oe  = dir_q;
  assign pad_out = data_q & dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [REG_AW-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic              bus_rvalid,
  input logic [PINS-1:0]   pad_oe,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic [PINS-1:0]   stat,
  input logic [PINS-1:0]   mask
);
  localparam int HALF = PINS / 2;

  logic stat_wr;
  assign stat_wr = bus_valid && bus_write && bus_addr == RA_STAT;

  p_dir_to_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == RA_DIR) |=> pad_oe == $past(bus_wdata));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (stat & $past(stat)) == $past(stat));

  p_zero_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (!irq_lo && !irq_hi));

  p_lo_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (|mask[HALF-1:0]));

  p_hi_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (|mask[PINS-1:HALF]));

  p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  p_no_spurious_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .pad_oe     (pad_oe),
  .irq_lo     (irq_lo),
  .irq_hi     (irq_hi),
  .stat       (stat_q),
  .mask       (mask_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  import gpio_irq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0, bus_write = 1'b0;
  logic [REG_AW-1:0] bus_addr = '0;
  logic [PINS-1:0]   bus_wdata = '0;
  logic              bus_rvalid;
  logic [PINS-1:0]   bus_rdata;
  logic [PINS-1:0]   pad_in = '0;
  logic [PINS-1:0]   pad_out, pad_oe;
  logic              irq_lo, irq_hi;

  int n_checks = 0, n_fail = 0;
  logic [PINS-1:0] exp_q[$];
  string           tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input string tag, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected value for every read response.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected response", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [REG_AW-1:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, input logic [PINS-1:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    check("watchdog expired", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 pad_oe reset", pad_oe, '0);
    check("R10 pad_out reset", pad_out, '0);
    check("R10 irq reset", {30'd0, irq_hi, irq_lo}, '0);
    rd(RA_DATA, '0, "R10 data reg reset");
    rd(RA_MASK, '0, "R10 mask reg reset");

    // R1 output path
    pad_in = 32'h0F0F_F0F0;
    wr(RA_DATA, 32'hA5A5_0F0F);
    wr(RA_DIR,  32'hFFFF_0000);
    check("R1 pad_oe follows direction", pad_oe, 32'hFFFF_0000);
    check("R1 pad_out gated by direction", pad_out, 32'hA5A5_0000);
    rd(RA_DATA, 32'hA5A5_0F0F, "R1 data readback ignores pins");

    // R2 synchronized pad level, write ignored
    pad_in = 32'h1234_5678;
    settle();
    rd(RA_PAD, 32'h1234_5678, "R2 pad level");
    wr(RA_PAD, 32'hFFFF_FFFF);
    rd(RA_PAD, 32'h1234_5678, "R2 pad write ignored");
    pad_in = '0;
    settle();

    // Clean start: every pin on rising edge, clear all status
    wr(RA_CFG_LO, 32'hAAAA_AAAA);
    wr(RA_CFG_HI, 32'hAAAA_AAAA);
    wr(RA_STAT, 32'hFFFF_FFFF);
    rd(RA_STAT, '0, "R6 clear all");

    // R4 rising edge, pin 3
    pad_in[3] = 1'b1;
    settle();
    rd(RA_STAT, 32'h0000_0008, "R4 rising pin 3");
    check("R8 masked pin silent", {30'd0, irq_hi, irq_lo}, '0);
    wr(RA_MASK, 32'h0000_0008);
    check("R9 irq_lo from pin 3", {31'd0, irq_lo}, 32'd1);
    check("R9 irq_hi idle", {31'd0, irq_hi}, 32'd0);
    wr(RA_STAT, 32'h0000_0000);
    rd(RA_STAT, 32'h0000_0008, "R6 writing zero keeps bit");
    wr(RA_STAT, 32'h0000_0008);
    rd(RA_STAT, '0, "R6 write one clears");
    check("R8 irq_lo drops after clear", {31'd0, irq_lo}, 32'd0);
    pad_in[3] = 1'b0;
    settle();
    rd(RA_STAT, '0, "R4 rising ignores fall");

    // R3/R4 falling edge, pin 20 (upper field 4, bits 9:8 = 11)
    wr(RA_CFG_HI, 32'hAAAA_ABAA);
    pad_in[20] = 1'b1;
    settle();
    rd(RA_STAT, '0, "R4 falling ignores rise");
    pad_in[20] = 1'b0;
    settle();
    rd(RA_STAT, 32'h0010_0000, "R3 falling pin 20");
    wr(RA_MASK, 32'h0010_0000);
    check("R9 irq_hi from pin 20", {31'd0, irq_hi}, 32'd1);
    check("R9 irq_lo idle for pin 20", {31'd0, irq_lo}, 32'd0);
    wr(RA_STAT, 32'hFFFF_FFFF);
    rd(RA_STAT, '0, "R6 clear pin 20");

    // R7 high level, pin 5 (lower bits 11:10 = 01)
    wr(RA_CFG_LO, 32'hAAAA_A6AA);
    pad_in[5] = 1'b1;
    settle();
    rd(RA_STAT, 32'h0000_0020, "R4 high level pin 5");
    wr(RA_STAT, 32'h0000_0020);
    rd(RA_STAT, 32'h0000_0020, "R7 level reasserts over clear");
    pad_in[5] = 1'b0;
    settle();
    wr(RA_STAT, 32'h0000_0020);
    rd(RA_STAT, '0, "R7 clear sticks once level gone");

    // R3/R4 low level, pin 30 (upper bits 29:28 = 00), pin is low now
    wr(RA_CFG_HI, 32'h8AAA_ABAA);
    @(negedge clk);
    rd(RA_STAT, 32'h4000_0000, "R3 low level pin 30");
    pad_in[30] = 1'b1;
    settle();
    wr(RA_STAT, 32'hFFFF_FFFF);
    rd(RA_STAT, '0, "R4 low level ends when high");

    // R5 any-edge on pin 9 over a rising code
    wr(RA_ANYEDG, 32'h0000_0200);
    pad_in[9] = 1'b1;
    settle();
    rd(RA_STAT, 32'h0000_0200, "R5 any-edge rise pin 9");
    wr(RA_STAT, 32'h0000_0200);
    pad_in[9] = 1'b0;
    settle();
    rd(RA_STAT, 32'h0000_0200, "R5 any-edge fall pin 9");
    wr(RA_STAT, 32'hFFFF_FFFF);

    // R5 any-edge on pin 30 overrides the low-level code
    wr(RA_ANYEDG, 32'h4000_0200);
    pad_in[30] = 1'b0;
    settle();
    rd(RA_STAT, 32'h4000_0000, "R5 any-edge fall pin 30");
    wr(RA_STAT, 32'hFFFF_FFFF);
    rd(RA_STAT, '0, "R5 level code ignored");

    // R9 both halves together
    wr(RA_MASK, 32'hFFFF_FFFF);
    pad_in[3] = 1'b1; pad_in[9] = 1'b1; pad_in[30] = 1'b1;
    settle();
    rd(RA_STAT, 32'h4000_0208, "R9 status both halves");
    check("R9 both lines high", {30'd0, irq_hi, irq_lo}, 32'd3);
    wr(RA_STAT, 32'h0000_0208);
    check("R9 only upper line left", {30'd0, irq_hi, irq_lo}, 32'd2);
    wr(RA_STAT, 32'hFFFF_FFFF);
    check("R9 both lines low", {30'd0, irq_hi, irq_lo}, 32'd0);
    rd(RA_PAD, 32'h4000_0208, "R2 pad level final");

    repeat (3) @(negedge clk);
    check("R10 all responses seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule